// File: doc/BRIEF.md
# Translation Access-Rights and Fault-Priority Checker

This block sits right after a translation-buffer lookup. It receives the lookup result: a hit flag and the fields of the matching entry. These are the virtual window start, the physical base, the access id, two privilege bounds, a 3-bit rights type and three page flags (dirty, break and reference trap). It also receives the requested access kind, the current privilege level, a physical-mode flag, a protection-id check enable, four protection-id registers and a state-capture enable (the Q bit).

From these inputs the block produces the translated physical address, the read/write/execute rights mask it grants, and a 4-bit fault code. All three are registered and appear one cycle after the request. When a fault occurs and Q is set, the block also copies the faulting virtual address into two interruption registers: the low word into the offset register and the high word into the space register. Dispatching the exception and storing the translation entries are left to the surrounding logic.

The rights mask is 3 bits: bit 0 = read, bit 1 = write, bit 2 = execute. The access kind is 2 bits: 0 = none, 1 = read, 2 = write, 3 = execute.

Top module: `chk_access_unit`

## Requirements
- R1: With phys_mode set, out_pa equals the input address, out_rights is 3'b111 and out_fault is 0.
- R2: Outside physical mode, a lookup miss or a hit on an entry whose valid flag is clear gives out_rights 0 and out_pa 0. The fault is 1 (instruction miss) for an execute access and 2 (data miss) for any other kind.
- R3: On a usable hit, out_pa = ent_pa_base + (va − ent_va_begin), computed modulo the address width.
- R4: Read is allowed when priv <= ent_pl1. Write is allowed when priv <= ent_pl2. Execute is allowed when ent_pl2 <= priv <= ent_pl1.
- R5: The rights type filters the allowed rights. Type 0 keeps read. Type 1 keeps read and write. Type 2 keeps read and execute. Type 3 keeps all three. Types 4 to 7 keep execute only.
- R6: When pid_check_en is set and ent_aid is nonzero, the value 2*ent_aid+1 (zero-extended) is compared with each of the four protection-id registers. Any equality clears the write bit. A write access that matches ends with fault 5.
- R7: An access kind of none takes no fault after the protection-id step. It reports the mask left by R4 to R6.
- R8: If the requested right is absent from the mask, the fault is 3 for execute and 4 otherwise. No further steps run.
- R9: The page-flag steps apply in a fixed order, and a later step overrides an earlier one. First, a write with dirty clear gives fault 6. Next, a write with break set gives fault 7. Last, a non-execute access with the reference trap set gives fault 8.
- R10: Dirty clear and break set each remove write from the mask. Reference trap set leaves only execute.
- R11: When a request faults and q_bit is set, ior_q takes va[WORD_W-1:0] and isr_q takes the upper word. Otherwise both registers hold their values.
- R12: out_valid follows in_valid by exactly one cycle, and the outputs shown with it belong to that request. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| va | input | 2*WORD_W | Virtual address |
| acc_kind | input | 2 | 0 none, 1 read, 2 write, 3 execute |
| priv | input | 2 | Current privilege level |
| phys_mode | input | 1 | Translation bypass |
| pid_check_en | input | 1 | Protection-id check enable |
| q_bit | input | 1 | Enables interruption-register capture |
| pid_regs | input | NUM_PID*PID_W | Protection-id registers, register k at bits [k*PID_W +: PID_W] |
| tb_hit | input | 1 | Lookup found an entry |
| ent_valid | input | 1 | Entry valid flag |
| ent_va_begin | input | 2*WORD_W | Entry virtual start |
| ent_pa_base | input | 2*WORD_W | Entry physical base |
| ent_aid | input | AID_W | Entry access id |
| ent_pl1 | input | 2 | Upper privilege bound |
| ent_pl2 | input | 2 | Lower privilege bound |
| ent_rtype | input | 3 | Rights type |
| ent_brk | input | 1 | Break flag |
| ent_dirty | input | 1 | Dirty flag |
| ent_ref_trap | input | 1 | Reference trap flag |
| out_valid | output | 1 | Result valid |
| out_pa | output | 2*WORD_W | Physical address |
| out_rights | output | 3 | Granted rights mask |
| out_fault | output | 4 | Fault code, 0 = none |
| ior_q | output | WORD_W | Offset interruption register |
| isr_q | output | WORD_W | Space interruption register |

## Verification
Directed patterns exercise each priority step in isolation, so that a code taken from the wrong step shows up. Examples are a write on a clean page against a write on a clean page that also has break set, and a read with the reference trap set against an execute with it set. Privilege windows are set so that read, write and execute disagree, which separates the three bound comparisons. Protection-id cases contrast a matching read, a matching write and a zero access id. A long randomised run then compares every output, and the captured interruption words, against a behavioural model each cycle. In that run the protection ids are often forced to match and misses are mixed in.

// File: rtl/chk_access_pkg.sv
package chk_access_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_EXEC  = 2'd3
  } acc_kind_t;

  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_IMISS   = 4'd1,
    FLT_DMISS   = 4'd2,
    FLT_IPROT   = 4'd3,
    FLT_DRIGHTS = 4'd4,
    FLT_PIDW    = 4'd5,
    FLT_DIRTY   = 4'd6,
    FLT_BREAK   = 4'd7,
    FLT_PREF    = 4'd8
  } flt_code_t;

  localparam int RB_READ  = 0;
  localparam int RB_WRITE = 1;
  localparam int RB_EXEC  = 2;

  localparam logic [2:0] MASK_ALL  = 3'b111;
  localparam logic [2:0] MASK_EXEC = 3'b100;

endpackage

// File: rtl/chk_rights_map.sv
module chk_rights_map
  import chk_access_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic [PL_W-1:0] priv,
  input  logic [PL_W-1:0] pl1,
  input  logic [PL_W-1:0] pl2,
  input  logic [2:0]      rtype,
  output logic [2:0]      mask
);

  logic can_rd, can_wr, can_ex;

  always_comb begin
    can_rd = (priv <= pl1);
    can_wr = (priv <= pl2);
    can_ex = (pl2 <= priv) && (priv <= pl1);
    mask   = '0;
    case (rtype)
      3'd0: mask[RB_READ] = can_rd;
      3'd1: begin
        mask[RB_READ]  = can_rd;
        mask[RB_WRITE] = can_wr;
      end
      3'd2: begin
        mask[RB_READ] = can_rd;
        mask[RB_EXEC] = can_ex;
      end
      3'd3: begin
        mask[RB_READ]  = can_rd;
        mask[RB_WRITE] = can_wr;
        mask[RB_EXEC]  = can_ex;
      end
      default: mask[RB_EXEC] = can_ex;
    endcase
  end

endmodule

// File: rtl/chk_pid_match.sv
module chk_pid_match #(
  parameter int AID_W   = 18,
  parameter int PID_W   = 32,
  parameter int NUM_PID = 4
) (
  input  logic [AID_W-1:0]         aid,
  input  logic                     enable,
  input  logic [NUM_PID*PID_W-1:0] pid_regs,
  output logic                     hit
);

  logic [PID_W-1:0]   key;
  logic [NUM_PID-1:0] eq_vec;

  always_comb begin
    key            = '0;
    key[AID_W:0]   = {aid, 1'b1};
  end

  for (genvar k = 0; k < NUM_PID; k++) begin : g_cmp
    assign eq_vec[k] = (pid_regs[k*PID_W +: PID_W] == key);
  end

  assign hit = enable && (aid != '0) && (|eq_vec);

endmodule

// File: rtl/chk_fault_seq.sv
module chk_fault_seq
  import chk_access_pkg::*;
(
  input  logic [1:0] acc_kind,
  input  logic [2:0] base_mask,
  input  logic       pid_hit,
  input  logic       dirty,
  input  logic       brk,
  input  logic       ref_trap,
  output logic [2:0] mask,
  output logic [3:0] code
);

  acc_kind_t  kind;
  logic [2:0] want;
  logic       is_wr, is_ex, done;

  always_comb begin
    kind  = acc_kind_t'(acc_kind);
    is_wr = (kind == ACC_WRITE);
    is_ex = (kind == ACC_EXEC);
    want  = '0;
    case (kind)
      ACC_READ:  want[RB_READ]  = 1'b1;
      ACC_WRITE: want[RB_WRITE] = 1'b1;
      ACC_EXEC:  want[RB_EXEC]  = 1'b1;
      default:   want = '0;
    endcase

    mask = base_mask;
    code = FLT_NONE;
    done = (kind == ACC_NONE);

    if (pid_hit) begin
      mask[RB_WRITE] = 1'b0;
      if (is_wr) begin
        code = FLT_PIDW;
        done = 1'b1;
      end
    end

    if (!done) begin
      if ((mask & want) == 3'b000) begin
        code = is_ex ? FLT_IPROT : FLT_DRIGHTS;
      end else begin
        if (!dirty) begin
          if (is_wr) code = FLT_DIRTY;
          mask[RB_WRITE] = 1'b0;
        end
        if (brk) begin
          if (is_wr) code = FLT_BREAK;
          mask[RB_WRITE] = 1'b0;
        end
        if (ref_trap) begin
          if (!is_ex) code = FLT_PREF;
          mask = mask & MASK_EXEC;
        end
      end
    end
  end

endmodule

// File: rtl/chk_access_unit.sv
module chk_access_unit
  import chk_access_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int AID_W   = 18,
  parameter int PID_W   = 32,
  parameter int NUM_PID = 4,
  parameter int PL_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [2*WORD_W-1:0]      va,
  input  logic [1:0]               acc_kind,
  input  logic [PL_W-1:0]          priv,
  input  logic                     phys_mode,
  input  logic                     pid_check_en,
  input  logic                     q_bit,
  input  logic [NUM_PID*PID_W-1:0] pid_regs,
  input  logic                     tb_hit,
  input  logic                     ent_valid,
  input  logic [2*WORD_W-1:0]      ent_va_begin,
  input  logic [2*WORD_W-1:0]      ent_pa_base,
  input  logic [AID_W-1:0]         ent_aid,
  input  logic [PL_W-1:0]          ent_pl1,
  input  logic [PL_W-1:0]          ent_pl2,
  input  logic [2:0]               ent_rtype,
  input  logic                     ent_brk,
  input  logic                     ent_dirty,
  input  logic                     ent_ref_trap,
  output logic                     out_valid,
  output logic [2*WORD_W-1:0]      out_pa,
  output logic [2:0]               out_rights,
  output logic [3:0]               out_fault,
  output logic [WORD_W-1:0]        ior_q,
  output logic [WORD_W-1:0]        isr_q
);

  localparam int VA_W = 2 * WORD_W;

  logic [2:0]      type_mask;
  logic            pid_hit;
  logic [2:0]      seq_mask;
  logic [3:0]      seq_code;
  logic [VA_W-1:0] nxt_pa;
  logic [2:0]      nxt_rights;
  logic [3:0]      nxt_fault;
  logic            usable;

  chk_rights_map #(.PL_W(PL_W)) u_rights (
    .priv  (priv),
    .pl1   (ent_pl1),
    .pl2   (ent_pl2),
    .rtype (ent_rtype),
    .mask  (type_mask)
  );

  chk_pid_match #(.AID_W(AID_W), .PID_W(PID_W), .NUM_PID(NUM_PID)) u_pid (
    .aid      (ent_aid),
    .enable   (pid_check_en),
    .pid_regs (pid_regs),
    .hit      (pid_hit)
  );

  chk_fault_seq u_seq (
    .acc_kind  (acc_kind),
    .base_mask (type_mask),
    .pid_hit   (pid_hit),
    .dirty     (ent_dirty),
    .brk       (ent_brk),
    .ref_trap  (ent_ref_trap),
    .mask      (seq_mask),
    .code      (seq_code)
  );

  always_comb begin
    usable = tb_hit && ent_valid;
    if (phys_mode) begin
      nxt_pa     = va;
      nxt_rights = MASK_ALL;
      nxt_fault  = FLT_NONE;
    end else if (!usable) begin
      nxt_pa     = '0;
      nxt_rights = '0;
      nxt_fault  = (acc_kind_t'(acc_kind) == ACC_EXEC) ? FLT_IMISS : FLT_DMISS;
    end else begin
      nxt_pa     = ent_pa_base + (va - ent_va_begin);
      nxt_rights = seq_mask;
      nxt_fault  = seq_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_pa     <= '0;
      out_rights <= '0;
      out_fault  <= '0;
      ior_q      <= '0;
      isr_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pa     <= nxt_pa;
        out_rights <= nxt_rights;
        out_fault  <= nxt_fault;
        if (q_bit && (nxt_fault != FLT_NONE)) begin
          ior_q <= va[WORD_W-1:0];
          isr_q <= va[VA_W-1:WORD_W];
        end
      end
    end
  end

endmodule

// File: rtl/chk_access_props.sv
module chk_access_props #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                phys_mode,
  input logic                tb_hit,
  input logic                ent_valid,
  input logic [1:0]          acc_kind,
  input logic [2*WORD_W-1:0] va,
  input logic                out_valid,
  input logic [2*WORD_W-1:0] out_pa,
  input logic [2:0]          out_rights,
  input logic [3:0]          out_fault,
  input logic [WORD_W-1:0]   ior_q,
  input logic [WORD_W-1:0]   isr_q
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_phys_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && phys_mode |=> out_rights == 3'b111 && out_fault == 4'd0 && out_pa == $past(va));

  p_miss_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && !phys_mode && !(tb_hit && ent_valid) |=>
      out_rights == 3'b000 && out_fault == (($past(acc_kind) == 2'd3) ? 4'd1 : 4'd2));

  p_pidw_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_fault == 4'd5 |-> !out_rights[1]);

  p_pref_strip_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_fault == 4'd8 |-> out_rights[1:0] == 2'b00);

  p_capture_hold_r11: assert property (@(posedge clk) disable iff (rst)
    armed && !(out_valid && out_fault != 4'd0) |-> $stable(ior_q) && $stable(isr_q));

  p_valid_follow_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

endmodule

bind chk_access_unit chk_access_props #(.WORD_W(WORD_W)) u_props (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .phys_mode  (phys_mode),
  .tb_hit     (tb_hit),
  .ent_valid  (ent_valid),
  .acc_kind   (acc_kind),
  .va         (va),
  .out_valid  (out_valid),
  .out_pa     (out_pa),
  .out_rights (out_rights),
  .out_fault  (out_fault),
  .ior_q      (ior_q),
  .isr_q      (isr_q)
);

// File: tb/chk_access_unit_test.sv
module chk_access_unit_test;

  localparam int WORD_W = 32;
  localparam int AID_W  = 18;
  localparam int PID_W  = 32;
  localparam int NPID   = 4;

  typedef struct {
    logic        vld;
    logic [63:0] va;
    logic [1:0]  kind;
    logic [1:0]  priv;
    logic        phys, pen, q;
    logic [127:0] pids;
    logic        hit, ev;
    logic [63:0] vbeg, pbase;
    logic [17:0] aid;
    logic [1:0]  pl1, pl2;
    logic [2:0]  rt;
    logic        b, d, t;
  } stim_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic         in_valid = 0;
  logic [63:0]  va = 0;
  logic [1:0]   acc_kind = 0, priv = 0, ent_pl1 = 0, ent_pl2 = 0;
  logic         phys_mode = 0, pid_check_en = 0, q_bit = 0;
  logic [127:0] pid_regs = 0;
  logic         tb_hit = 0, ent_valid = 0, ent_brk = 0, ent_dirty = 0, ent_ref_trap = 0;
  logic [63:0]  ent_va_begin = 0, ent_pa_base = 0;
  logic [17:0]  ent_aid = 0;
  logic [2:0]   ent_rtype = 0;
  logic         out_valid;
  logic [63:0]  out_pa;
  logic [2:0]   out_rights;
  logic [3:0]   out_fault;
  logic [31:0]  ior_q, isr_q;

  chk_access_unit #(.WORD_W(WORD_W), .AID_W(AID_W), .PID_W(PID_W), .NUM_PID(NPID)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .va(va), .acc_kind(acc_kind), .priv(priv),
    .phys_mode(phys_mode), .pid_check_en(pid_check_en), .q_bit(q_bit), .pid_regs(pid_regs),
    .tb_hit(tb_hit), .ent_valid(ent_valid), .ent_va_begin(ent_va_begin),
    .ent_pa_base(ent_pa_base), .ent_aid(ent_aid), .ent_pl1(ent_pl1), .ent_pl2(ent_pl2),
    .ent_rtype(ent_rtype), .ent_brk(ent_brk), .ent_dirty(ent_dirty),
    .ent_ref_trap(ent_ref_trap), .out_valid(out_valid), .out_pa(out_pa),
    .out_rights(out_rights), .out_fault(out_fault), .ior_q(ior_q), .isr_q(isr_q));

  int total = 0;
  int bad = 0;
  logic [31:0] m_ior = 0, m_isr = 0;
  logic [63:0] m_pa = 0;
  logic [2:0]  m_rights = 0;
  logic [3:0]  m_fault = 0;
  logic        m_valid = 0;

  // behavioural reference of the whole check chain
  task automatic model(input stim_t s);
    int r, w, x, p;
    int pidm;
    logic [31:0] key;
    bit skip;
    m_valid = s.vld;
    if (!s.vld) return;
    p = s.priv;
    if (s.phys) begin
      m_pa = s.va; m_rights = 3'b111; m_fault = 0;
    end else if (!(s.hit && s.ev)) begin
      m_pa = 0; m_rights = 0; m_fault = (s.kind == 3) ? 4'd1 : 4'd2;
    end else begin
      m_pa = s.pbase + s.va - s.vbeg;
      r = (p <= s.pl1); w = (p <= s.pl2); x = (s.pl2 <= p && p <= s.pl1);
      if (s.rt == 0) begin w = 0; x = 0; end
      else if (s.rt == 1) x = 0;
      else if (s.rt == 2) w = 0;
      else if (s.rt >= 4) begin r = 0; w = 0; end
      m_fault = 0; skip = (s.kind == 0);
      key = {13'd0, s.aid, 1'b1};
      pidm = 0;
      for (int k = 0; k < NPID; k++) if (s.pids[k*32 +: 32] == key) pidm = 1;
      if (s.pen && s.aid != 0 && pidm == 1) begin
        w = 0;
        if (s.kind == 2) begin m_fault = 5; skip = 1; end
      end
      if (!skip) begin
        if ((s.kind == 1 && r == 0) || (s.kind == 2 && w == 0) || (s.kind == 3 && x == 0))
          m_fault = (s.kind == 3) ? 4'd3 : 4'd4;
        else begin
          if (s.t && s.kind != 3) m_fault = 8;
          else if (s.b && s.kind == 2) m_fault = 7;
          else if (!s.d && s.kind == 2) m_fault = 6;
          if (!s.d || s.b) w = 0;
          if (s.t) begin r = 0; w = 0; end
        end
      end
      m_rights = {x[0], w[0], r[0]};
    end
    if (s.q && m_fault != 0) begin m_ior = s.va[31:0]; m_isr = s.va[63:32]; end
  endtask

  task automatic drive(input stim_t s);
    in_valid = s.vld; va = s.va; acc_kind = s.kind; priv = s.priv;
    phys_mode = s.phys; pid_check_en = s.pen; q_bit = s.q; pid_regs = s.pids;
    tb_hit = s.hit; ent_valid = s.ev; ent_va_begin = s.vbeg; ent_pa_base = s.pbase;
    ent_aid = s.aid; ent_pl1 = s.pl1; ent_pl2 = s.pl2; ent_rtype = s.rt;
    ent_brk = s.b; ent_dirty = s.d; ent_ref_trap = s.t;
  endtask

  task automatic compare(input string tag);
    bit ok;
    total++;
    ok = (out_valid == m_valid) && (ior_q == m_ior) && (isr_q == m_isr);
    if (m_valid) ok = ok && (out_pa == m_pa) && (out_rights == m_rights) && (out_fault == m_fault);
    if (!ok) begin
      bad++;
      $display("FAIL %s: got v=%0b pa=%h r=%b f=%0d ior=%h isr=%h exp v=%0b pa=%h r=%b f=%0d ior=%h isr=%h",
               tag, out_valid, out_pa, out_rights, out_fault, ior_q, isr_q,
               m_valid, m_pa, m_rights, m_fault, m_ior, m_isr);
    end
  endtask

  task automatic run(input stim_t s, input string tag);
    @(negedge clk);
    drive(s);
    model(s);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic stim_t base();
    stim_t s;
    s.vld = 1; s.va = 64'h0000_0001_0000_3456; s.kind = 1; s.priv = 0;
    s.phys = 0; s.pen = 1; s.q = 0; s.pids = '0; s.hit = 1; s.ev = 1;
    s.vbeg = 64'h0000_0001_0000_3000; s.pbase = 64'h0000_0000_0088_0000;
    s.aid = 18'h155; s.pl1 = 3; s.pl2 = 3; s.rt = 3; s.b = 0; s.d = 1; s.t = 0;
    return s;
  endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got hung exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    stim_t s;
    repeat (3) @(negedge clk);
    rst = 0;
    m_valid = 0; m_pa = 0; m_rights = 0; m_fault = 0;
    total++;
    if (out_valid !== 0 || out_pa !== 0 || out_rights !== 0 || out_fault !== 0 || ior_q !== 0 || isr_q !== 0) begin
      bad++; $display("FAIL R12 reset: got v=%0b f=%0d exp zeros", out_valid, out_fault);
    end

    s = base(); s.phys = 1; s.kind = 3; s.hit = 0; run(s, "R1 physical");
    s = base(); s.hit = 0; run(s, "R2 miss read");
    s = base(); s.hit = 0; s.kind = 3; s.q = 1; run(s, "R2 miss exec");
    s = base(); s.ev = 0; s.kind = 2; run(s, "R2 invalid entry");
    s = base(); run(s, "R3 translate");
    s = base(); s.va = 64'h0000_0001_0000_2fff; run(s, "R3 below begin");
    s = base(); s.priv = 2; s.pl1 = 1; run(s, "R4 read denied");
    s = base(); s.priv = 3; s.pl1 = 2; s.pl2 = 1; s.kind = 3; run(s, "R4 exec above window");
    s = base(); s.priv = 2; s.pl1 = 2; s.pl2 = 1; s.kind = 3; s.rt = 2; run(s, "R4 exec inside window");
    s = base(); s.priv = 1; s.pl2 = 0; s.kind = 2; run(s, "R4 write denied");
    s = base(); s.rt = 0; s.kind = 2; run(s, "R5 type0 write");
    s = base(); s.rt = 5; s.kind = 1; run(s, "R5 type5 read");
    s = base(); s.rt = 3; s.kind = 3; run(s, "R5 type3 exec");
    s = base(); s.pids[64 +: 32] = {13'd0, s.aid, 1'b1}; s.kind = 2; s.q = 1; run(s, "R6 pid write");
    s = base(); s.pids[96 +: 32] = {13'd0, s.aid, 1'b1}; run(s, "R6 pid read");
    s = base(); s.aid = 0; s.pids[31:0] = 32'd1; s.kind = 2; run(s, "R6 zero aid");
    s = base(); s.pids[31:0] = {13'd0, s.aid, 1'b1}; s.pen = 0; s.kind = 2; run(s, "R6 check off");
    s = base(); s.kind = 0; s.d = 0; s.t = 1; s.rt = 0; s.priv = 3; s.pl1 = 0; run(s, "R7 none");
    s = base(); s.kind = 3; s.rt = 0; run(s, "R8 exec missing");
    s = base(); s.kind = 2; s.d = 0; run(s, "R9 dirty");
    s = base(); s.kind = 2; s.d = 0; s.b = 1; run(s, "R9 break over dirty");
    s = base(); s.kind = 2; s.b = 1; s.t = 1; run(s, "R9 ref over break");
    s = base(); s.kind = 3; s.t = 1; s.b = 1; run(s, "R9 exec with trap");
    s = base(); s.kind = 1; s.b = 1; s.d = 0; run(s, "R10 strip write");
    s = base(); s.kind = 1; s.t = 1; run(s, "R10 trap strip");
    s = base(); s.hit = 0; s.q = 1; s.va = 64'hdead_beef_1234_5678; run(s, "R11 capture");
    s = base(); s.hit = 0; s.q = 0; s.va = 64'h1111_2222_3333_4444; run(s, "R11 no q");
    s = base(); s.q = 1; s.va = 64'h5555_6666_0000_3000; run(s, "R11 no fault");
    s = base(); s.vld = 0; run(s, "R12 idle");
    s = base(); s.vld = 0; s.hit = 0; s.q = 1; run(s, "R12 idle ignores");

    for (int i = 0; i < 4000; i++) begin
      s = base();
      s.vld = ($urandom % 8) != 0;
      s.va = {32'($urandom % 4), $urandom};
      s.vbeg = {32'($urandom % 4), $urandom};
      s.pbase = {$urandom, $urandom};
      s.kind = 2'($urandom); s.priv = 2'($urandom);
      s.phys = ($urandom % 10) == 0; s.pen = 1'($urandom); s.q = 1'($urandom);
      s.hit = ($urandom % 8) != 0; s.ev = ($urandom % 8) != 0;
      s.aid = ($urandom % 4 == 0) ? 18'd0 : 18'($urandom);
      s.pl1 = 2'($urandom); s.pl2 = 2'($urandom); s.rt = 3'($urandom);
      s.b = 1'($urandom); s.d = 1'($urandom); s.t = ($urandom % 4) == 0;
      s.pids = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 3 == 0) s.pids[($urandom % 4) * 32 +: 32] = {13'd0, s.aid, 1'b1};
      run(s, "R5 R9 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule